// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry Selection

This unit performs every integer addition and subtraction variant of a fixed-point pipeline with a single adder. An operand inverter, a second-operand selector (register B, zero, all ones, sign-extended immediate, or high-placed immediate) and a carry-in selector (0, 1, stored carry, stored overflow) cover reverse subtraction, extended (multi-word) add and subtract, minus-one and zero forms, negation, and immediate forms.

The unit owns the arithmetic status state: carry at full width and at 32 bits, overflow at full width and at 32 bits, a sticky summary-overflow bit, and a three-bit sign/zero field. Each issued operation writes the result register one clock later. Each status group changes only when the operation or its record and overflow-enable bits allow it. Instruction decode and the register file sit outside the unit.

Top module: `addsub_carry_unit`

## Requirements
- R1: `op_i` codes give x + y + cin as follows (x is A or ~A, y is the second operand): 0 A+B+0; 1 ~A+B+1; 2 A+B+0 with carry write; 3 ~A+B+1 with carry write; 4 A+B+CA; 5 ~A+B+CA; 6 A+ones+CA; 7 ~A+ones+CA; 8 A+0+CA; 9 ~A+0+CA; 10 ~A+0+1; 11 A+simm+0; 12 A+(simm shifted up 16)+0; 13 A+simm+0 with carry write; 14 ~A+simm+1 with carry write; 15 A+B+OV.
- R2: On a clock edge with `issue_i` high, `sum_o` takes the W-bit sum. While `issue_i` is low, every output holds its value.
- R3: Codes 2 to 9, 13 and 14 write `ca_o` with the carry out of the top bit and `ca32_o` with the carry out of bit 31 (counting from bit 0). All other codes leave both bits unchanged.
- R4: When `ra_zero_i` is high, codes 11 and 12 use zero in place of A. All other codes ignore `ra_zero_i`.
- R5: The 16-bit immediate is sign-extended to W bits. For code 12, the immediate occupies bits 31:16, bits 15:0 are zero, and the value is sign-extended from bit 31.
- R6: With `ovf_en_i` high on a code other than 15, `ov_o` takes the full-width signed overflow and `ov32_o` takes the signed overflow of the low 32-bit addition. With `ovf_en_i` low, both bits hold.
- R7: `so_o` is set whenever an overflow-enabled operation sets `ov_o`. No operation clears it, and only reset does.
- R8: Code 15 uses the stored `ov_o` as carry-in. It writes its top-bit carry to `ov_o` and its bit-31 carry to `ov32_o`, ignores `ovf_en_i`, and leaves `ca_o`, `ca32_o` and `so_o` unchanged.
- R9: With `rec_i` high, `cr_o` takes {negative, positive, zero} of the full-width signed sum (bit 2 negative, bit 1 positive, bit 0 zero). With `rec_i` low, `cr_o` holds.
- R10: Reset sets `sum_o`, `cr_o` and all status bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation valid this cycle |
| op_i | input | 4 | Operation code (see R1) |
| a_i | input | W | First register operand |
| b_i | input | W | Second register operand |
| imm_i | input | 16 | Signed immediate |
| ra_zero_i | input | 1 | First register specifier is 0 (immediate add forms) |
| rec_i | input | 1 | Record enable for the compare field |
| ovf_en_i | input | 1 | Overflow-enable bit |
| sum_o | output | W | Registered result |
| ca_o | output | 1 | Stored carry |
| ca32_o | output | 1 | Stored carry out of bit 31 |
| ov_o | output | 1 | Stored overflow |
| ov32_o | output | 1 | Stored 32-bit overflow |
| so_o | output | 1 | Sticky summary overflow |
| cr_o | output | 3 | {negative, positive, zero} |

## Verification
The hardest states to reach are those where an operation depends on stored status, because the carry-in comes from a previous operation.

- For the extended forms, a carry-writing add first loads a known carry, and the stimulus then chains a 128-bit addition across two issues.
- For the overflow-carry form, an overflow-enabled add first loads `ov_o`, or a preceding overflow-carry add does. The stimulus then shows that CA and the sticky bit stay put.
- For the 32-bit overflow bit, operands are chosen whose low halves overflow while the full width does not, so that OV32 and OV split apart.

// File: rtl/acu_pkg.sv
package acu_pkg;

  typedef enum logic [3:0] {
    OP_ADD     = 4'd0,
    OP_RSUB    = 4'd1,
    OP_ADD_C   = 4'd2,
    OP_RSUB_C  = 4'd3,
    OP_ADD_X   = 4'd4,
    OP_RSUB_X  = 4'd5,
    OP_ADD_M1  = 4'd6,
    OP_RSUB_M1 = 4'd7,
    OP_ADD_Z   = 4'd8,
    OP_RSUB_Z  = 4'd9,
    OP_NEG     = 4'd10,
    OP_ADD_I   = 4'd11,
    OP_ADD_IH  = 4'd12,
    OP_ADD_IC  = 4'd13,
    OP_RSUB_IC = 4'd14,
    OP_ADD_OVC = 4'd15
  } acu_op_e;

  typedef enum logic [2:0] {
    YS_B, YS_ZERO, YS_ONES, YS_IMM, YS_IMMH
  } ysel_e;

  typedef enum logic [1:0] {
    CS_ZERO, CS_ONE, CS_CA, CS_OV
  } csel_e;

  typedef struct packed {
    logic  inv_a;
    logic  zero_ok;
    ysel_e ysel;
    csel_e csel;
    logic  wr_ca;
    logic  ovc;
  } acu_ctl_t;

  function automatic acu_ctl_t acu_decode(acu_op_e op);
    acu_ctl_t c;
    c = '{inv_a: 1'b0, zero_ok: 1'b0, ysel: YS_B, csel: CS_ZERO,
          wr_ca: 1'b0, ovc: 1'b0};
    case (op)
      OP_ADD:     ;
      OP_RSUB:    begin c.inv_a = 1'b1; c.csel = CS_ONE; end
      OP_ADD_C:   c.wr_ca = 1'b1;
      OP_RSUB_C:  begin c.inv_a = 1'b1; c.csel = CS_ONE; c.wr_ca = 1'b1; end
      OP_ADD_X:   begin c.csel = CS_CA; c.wr_ca = 1'b1; end
      OP_RSUB_X:  begin c.inv_a = 1'b1; c.csel = CS_CA; c.wr_ca = 1'b1; end
      OP_ADD_M1:  begin c.ysel = YS_ONES; c.csel = CS_CA; c.wr_ca = 1'b1; end
      OP_RSUB_M1: begin c.inv_a = 1'b1; c.ysel = YS_ONES; c.csel = CS_CA; c.wr_ca = 1'b1; end
      OP_ADD_Z:   begin c.ysel = YS_ZERO; c.csel = CS_CA; c.wr_ca = 1'b1; end
      OP_RSUB_Z:  begin c.inv_a = 1'b1; c.ysel = YS_ZERO; c.csel = CS_CA; c.wr_ca = 1'b1; end
      OP_NEG:     begin c.inv_a = 1'b1; c.ysel = YS_ZERO; c.csel = CS_ONE; end
      OP_ADD_I:   begin c.ysel = YS_IMM; c.zero_ok = 1'b1; end
      OP_ADD_IH:  begin c.ysel = YS_IMMH; c.zero_ok = 1'b1; end
      OP_ADD_IC:  begin c.ysel = YS_IMM; c.wr_ca = 1'b1; end
      OP_RSUB_IC: begin c.inv_a = 1'b1; c.ysel = YS_IMM; c.csel = CS_ONE; c.wr_ca = 1'b1; end
      OP_ADD_OVC: begin c.csel = CS_OV; c.ovc = 1'b1; end
      default:    ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/acu_operand_mux.sv
module acu_operand_mux
  import acu_pkg::*;
#(
  parameter int W = 64
) (
  input  acu_ctl_t       ctl,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [15:0]    imm,
  input  logic           ra_zero,
  input  logic           ca,
  input  logic           ov,
  output logic [W-1:0]   x,
  output logic [W-1:0]   y,
  output logic           cin
);
  localparam int IMM_W = 16;

  logic [W-1:0] a_eff;
  logic [W-1:0] imm_lo;
  logic [W-1:0] imm_hi;

  assign imm_lo = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
  assign imm_hi = {{(W-2*IMM_W){imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};

  always_comb begin
    a_eff = (ctl.zero_ok && ra_zero) ? '0 : a;
    x     = ctl.inv_a ? ~a_eff : a_eff;
    case (ctl.ysel)
      YS_B:    y = b;
      YS_ZERO: y = '0;
      YS_ONES: y = '1;
      YS_IMM:  y = imm_lo;
      YS_IMMH: y = imm_hi;
      default: y = '0;
    endcase
    case (ctl.csel)
      CS_ZERO: cin = 1'b0;
      CS_ONE:  cin = 1'b1;
      CS_CA:   cin = ca;
      CS_OV:   cin = ov;
      default: cin = 1'b0;
    endcase
  end

  // R4
  always_comb begin
    ra_zero_gate_chk: assert (ctl.zero_ok || !ra_zero || ctl.inv_a || x == a);
  end
endmodule

// File: rtl/acu_adder.sv
module acu_adder #(
  parameter int W  = 64,
  parameter int LW = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout,
  output logic         c_lo,
  output logic         ovf,
  output logic         ovf_lo
);
  logic [W:0] full;
  logic       c_into_msb;

  assign full       = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign s          = full[W-1:0];
  assign cout       = full[W];
  assign c_into_msb = s[W-1] ^ x[W-1] ^ y[W-1];
  assign ovf        = cout ^ c_into_msb;

  generate
    if (W > LW) begin : g_wide
      logic c_into_lo_msb;
      assign c_lo          = s[LW] ^ x[LW] ^ y[LW];
      assign c_into_lo_msb = s[LW-1] ^ x[LW-1] ^ y[LW-1];
      assign ovf_lo        = c_lo ^ c_into_lo_msb;
    end else begin : g_narrow
      assign c_lo   = cout;
      assign ovf_lo = ovf;
    end
  endgenerate

  // R6
  always_comb begin
    same_sign_ovf_chk: assert (!ovf || (x[W-1] == y[W-1] && s[W-1] != x[W-1]));
  end
endmodule

// File: rtl/acu_flag_file.sv
module acu_flag_file #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue,
  input  logic         wr_ca,
  input  logic         ovc,
  input  logic         ov_en,
  input  logic         rec,
  input  logic [W-1:0] s,
  input  logic         cout,
  input  logic         c_lo,
  input  logic         ovf,
  input  logic         ovf_lo,
  output logic [W-1:0] sum_q,
  output logic         ca_q,
  output logic         ca32_q,
  output logic         ov_q,
  output logic         ov32_q,
  output logic         so_q,
  output logic [2:0]   cr_q
);
  logic [W-1:0] sum_d;
  logic         ca_d, ca32_d, ov_d, ov32_d, so_d;
  logic [2:0]   cr_d;
  logic         neg, zero;

  assign neg  = s[W-1];
  assign zero = (s == '0);

  always_comb begin
    sum_d  = sum_q;
    ca_d   = ca_q;
    ca32_d = ca32_q;
    ov_d   = ov_q;
    ov32_d = ov32_q;
    so_d   = so_q;
    cr_d   = cr_q;
    if (issue) begin
      sum_d = s;
      if (wr_ca) begin
        ca_d   = cout;
        ca32_d = c_lo;
      end
      if (ovc) begin
        ov_d   = cout;
        ov32_d = c_lo;
      end else if (ov_en) begin
        ov_d   = ovf;
        ov32_d = ovf_lo;
        so_d   = so_q | ovf;
      end
      if (rec) cr_d = {neg, !neg && !zero, zero};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      ca_q   <= 1'b0;
      ca32_q <= 1'b0;
      ov_q   <= 1'b0;
      ov32_q <= 1'b0;
      so_q   <= 1'b0;
      cr_q   <= 3'b000;
    end else begin
      sum_q  <= sum_d;
      ca_q   <= ca_d;
      ca32_q <= ca32_d;
      ov_q   <= ov_d;
      ov32_q <= ov32_d;
      so_q   <= so_d;
      cr_q   <= cr_d;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(sum_q) && $stable({ca_q, ca32_q, ov_q, ov32_q, so_q, cr_q}));
  // R7
  sticky_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_q |=> so_q);
  // R9
  cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr_q));
  // R9
  cr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !rec |=> $stable(cr_q));
endmodule

// File: rtl/addsub_carry_unit.sv
module addsub_carry_unit
  import acu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         issue_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [15:0]  imm_i,
  input  logic         ra_zero_i,
  input  logic         rec_i,
  input  logic         ovf_en_i,
  output logic [W-1:0] sum_o,
  output logic         ca_o,
  output logic         ca32_o,
  output logic         ov_o,
  output logic         ov32_o,
  output logic         so_o,
  output logic [2:0]   cr_o
);
  localparam int LW = 32;

  acu_ctl_t     ctl;
  logic [W-1:0] x, y, s;
  logic         cin, cout, c_lo, ovf, ovf_lo;

  assign ctl = acu_decode(acu_op_e'(op_i));

  acu_operand_mux #(.W(W)) u_mux (
    .ctl(ctl), .a(a_i), .b(b_i), .imm(imm_i), .ra_zero(ra_zero_i),
    .ca(ca_o), .ov(ov_o), .x(x), .y(y), .cin(cin)
  );

  acu_adder #(.W(W), .LW(LW)) u_add (
    .x(x), .y(y), .cin(cin), .s(s), .cout(cout), .c_lo(c_lo),
    .ovf(ovf), .ovf_lo(ovf_lo)
  );

  acu_flag_file #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .issue(issue_i), .wr_ca(ctl.wr_ca),
    .ovc(ctl.ovc), .ov_en(ovf_en_i), .rec(rec_i), .s(s), .cout(cout),
    .c_lo(c_lo), .ovf(ovf), .ovf_lo(ovf_lo), .sum_q(sum_o), .ca_q(ca_o),
    .ca32_q(ca32_o), .ov_q(ov_o), .ov32_q(ov32_o), .so_q(so_o), .cr_q(cr_o)
  );

  // R3
  ca_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !(op_i inside {4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd13, 4'd14})
    |=> $stable({ca_o, ca32_o}));
  // R8
  ovc_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && op_i == 4'd15 |=> $stable(so_o));
  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !ovf_en_i && op_i != 4'd15 |=> $stable({ov_o, ov32_o}));
endmodule

// File: tb/addsub_carry_unit_tb.sv
module addsub_carry_unit_tb;
  localparam int W = 64;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue_i;
  logic [3:0]   op_i;
  logic [W-1:0] a_i, b_i;
  logic [15:0]  imm_i;
  logic         ra_zero_i, rec_i, ovf_en_i;
  logic [W-1:0] sum_o;
  logic         ca_o, ca32_o, ov_o, ov32_o, so_o;
  logic [2:0]   cr_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [W-1:0] m_sum;
  logic         m_ca, m_ca32, m_ov, m_ov32, m_so;
  logic [2:0]   m_cr;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_carry_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .a_i(a_i),
    .b_i(b_i), .imm_i(imm_i), .ra_zero_i(ra_zero_i), .rec_i(rec_i),
    .ovf_en_i(ovf_en_i), .sum_o(sum_o), .ca_o(ca_o), .ca32_o(ca32_o),
    .ov_o(ov_o), .ov32_o(ov32_o), .so_o(so_o), .cr_o(cr_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " sum"}, sum_o, m_sum);
    chk({tag, " ca"}, {63'd0, ca_o}, {63'd0, m_ca});
    chk({tag, " ca32"}, {63'd0, ca32_o}, {63'd0, m_ca32});
    chk({tag, " ov"}, {63'd0, ov_o}, {63'd0, m_ov});
    chk({tag, " ov32"}, {63'd0, ov32_o}, {63'd0, m_ov32});
    chk({tag, " so"}, {63'd0, so_o}, {63'd0, m_so});
    chk({tag, " cr"}, {61'd0, cr_o}, {61'd0, m_cr});
  endtask

  // Reference model written from R1, R3-R9
  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [15:0] imm, input logic ra0, input logic rec, input logic oe);
    logic [W-1:0] x, y, se;
    logic         cin, wr, ovc, c, c32, o, o32;
    logic [W:0]   wide;
    logic [32:0]  low;
    se = {{48{imm[15]}}, imm};
    x = a; y = b; cin = 1'b0; wr = 1'b0; ovc = 1'b0;
    case (op)
      4'd0:  ;
      4'd1:  begin x = ~a; cin = 1'b1; end
      4'd2:  wr = 1'b1;
      4'd3:  begin x = ~a; cin = 1'b1; wr = 1'b1; end
      4'd4:  begin cin = m_ca; wr = 1'b1; end
      4'd5:  begin x = ~a; cin = m_ca; wr = 1'b1; end
      4'd6:  begin y = '1; cin = m_ca; wr = 1'b1; end
      4'd7:  begin x = ~a; y = '1; cin = m_ca; wr = 1'b1; end
      4'd8:  begin y = '0; cin = m_ca; wr = 1'b1; end
      4'd9:  begin x = ~a; y = '0; cin = m_ca; wr = 1'b1; end
      4'd10: begin x = ~a; y = '0; cin = 1'b1; end
      4'd11: begin x = ra0 ? '0 : a; y = se; end
      4'd12: begin x = ra0 ? '0 : a; y = se << 16; end
      4'd13: begin y = se; wr = 1'b1; end
      4'd14: begin x = ~a; y = se; cin = 1'b1; wr = 1'b1; end
      default: begin cin = m_ov; ovc = 1'b1; end
    endcase
    wide = {1'b0, x} + {1'b0, y} + {64'd0, cin};
    low  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, cin};
    c = wide[W]; c32 = low[32];
    o   = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
    o32 = (x[31] == y[31]) && (low[31] != x[31]);
    m_sum = wide[W-1:0];
    if (wr) begin m_ca = c; m_ca32 = c32; end
    if (ovc) begin m_ov = c; m_ov32 = c32; end
    else if (oe) begin m_ov = o; m_ov32 = o32; m_so = m_so | o; end
    if (rec) m_cr = {m_sum[W-1], !m_sum[W-1] && m_sum != '0, m_sum == '0};
  endtask

  task automatic run_op(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [15:0] imm, input logic ra0,
                        input logic rec, input logic oe);
    model(op, a, b, imm, ra0, rec, oe);
    issue_i = 1'b1; op_i = op; a_i = a; b_i = b; imm_i = imm;
    ra_zero_i = ra0; rec_i = rec; ovf_en_i = oe;
    @(negedge clk);
    issue_i = 1'b0;
    chk_all(tag);
  endtask

  task automatic t_reset();
    m_sum = '0; m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = 0;
    chk_all("R10 reset");
  endtask

  task automatic t_basic();
    run_op("R1 add", 4'd0, 64'd5, 64'd7, 16'd0, 0, 1, 0);
    chk("R1 add literal", sum_o, 64'd12);
    run_op("R1 rsub", 4'd1, 64'd3, 64'd10, 16'd0, 0, 1, 0);
    chk("R1 rsub literal", sum_o, 64'd7);
    run_op("R9 negative", 4'd1, 64'd10, 64'd3, 16'd0, 0, 1, 0);
    chk("R9 neg field", {61'd0, cr_o}, 64'd4);
    run_op("R9 zero", 4'd1, 64'd9, 64'd9, 16'd0, 0, 1, 0);
    run_op("R1 neg", 4'd10, 64'd1, 64'd0, 16'd0, 0, 1, 0);
    chk("R1 neg literal", sum_o, '1);
  endtask

  task automatic t_carry_chain();
    // 128-bit: {1, ffff..ff} + {2, 1}
    run_op("R3 addc low", 4'd2, '1, 64'd1, 16'd0, 0, 0, 0);
    chk("R3 ca set", {63'd0, ca_o}, 64'd1);
    run_op("R3 adde high", 4'd4, 64'd1, 64'd2, 16'd0, 0, 0, 0);
    chk("R3 adde literal", sum_o, 64'd4);
    run_op("R3 rsubc borrow", 4'd3, 64'd5, 64'd2, 16'd0, 0, 0, 0);
    run_op("R3 rsube", 4'd5, 64'd1, 64'd9, 16'd0, 0, 0, 0);
    run_op("R3 ca32 only", 4'd2, 64'h0000_0000_ffff_ffff, 64'd1, 16'd0, 0, 0, 0);
    chk("R3 ca32 literal", {62'd0, ca_o, ca32_o}, 64'd1);
    run_op("R3 addme", 4'd6, 64'd0, 64'd0, 16'd0, 0, 1, 0);
    run_op("R3 rsubme", 4'd7, 64'd4, 64'd0, 16'd0, 0, 1, 0);
    run_op("R3 addze", 4'd8, '1, 64'd0, 16'd0, 0, 1, 0);
    run_op("R3 rsubze", 4'd9, 64'd6, 64'd0, 16'd0, 0, 1, 0);
    run_op("R3 add no carry write", 4'd0, '1, '1, 16'd0, 0, 0, 0);
  endtask

  task automatic t_immediate();
    run_op("R4 addi ra0", 4'd11, 64'd100, 64'd0, 16'hfffe, 1, 1, 0);
    chk("R4 addi literal", sum_o, 64'hffff_ffff_ffff_fffe);
    run_op("R5 addi reg", 4'd11, 64'd100, 64'd0, 16'hfffe, 0, 1, 0);
    run_op("R5 addih", 4'd12, 64'd1, 64'd0, 16'h8000, 0, 1, 0);
    chk("R5 addih literal", sum_o, 64'hffff_ffff_8000_0001);
    run_op("R4 addih ra0", 4'd12, 64'd1, 64'd0, 16'h0001, 1, 1, 0);
    run_op("R4 addic ignores ra0", 4'd13, 64'd3, 64'd0, 16'hffff, 1, 1, 0);
    run_op("R3 rsubic", 4'd14, 64'd3, 64'd0, 16'd10, 0, 1, 0);
  endtask

  task automatic t_overflow();
    run_op("R6 ov32 only", 4'd0, 64'h0000_0000_7fff_ffff, 64'd1, 16'd0, 0, 0, 1);
    chk("R6 split", {62'd0, ov_o, ov32_o}, 64'd1);
    run_op("R6 ov full", 4'd0, 64'h7fff_ffff_ffff_ffff, 64'd1, 16'd0, 0, 1, 1);
    run_op("R7 so sticky", 4'd0, 64'd1, 64'd1, 16'd0, 0, 0, 1);
    chk("R7 so held", {63'd0, so_o}, 64'd1);
    run_op("R6 oe off holds", 4'd10, 64'h8000_0000_0000_0000, 64'd0, 16'd0, 0, 0, 0);
    run_op("R6 neg min", 4'd10, 64'h8000_0000_0000_0000, 64'd0, 16'd0, 0, 0, 1);
  endtask

  task automatic t_ovcarry();
    run_op("R8 load ov", 4'd0, 64'h7fff_ffff_ffff_ffff, 64'd1, 16'd0, 0, 0, 1);
    run_op("R8 ovc add", 4'd15, 64'd2, 64'd3, 16'd0, 0, 0, 1);
    chk("R8 literal", sum_o, 64'd6);
    run_op("R8 ovc carry", 4'd15, '1, 64'h0000_0000_0000_0002, 16'd0, 0, 0, 0);
    chk("R8 ov carry", {62'd0, ov_o, ov32_o}, 64'd3);
  endtask

  task automatic t_idle();
    issue_i = 1'b0; op_i = 4'd0; a_i = 64'd77; b_i = 64'd88; rec_i = 1'b1; ovf_en_i = 1'b1;
    @(negedge clk); @(negedge clk);
    chk_all("R2 idle hold");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue_i = 1'b0; op_i = '0; a_i = '0; b_i = '0; imm_i = '0;
    ra_zero_i = 1'b0; rec_i = 1'b0; ovf_en_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_carry_chain();
    t_immediate();
    t_overflow();
    t_ovcarry();
    t_idle();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule